// File: doc/BRIEF.md
# Physical memory protection checker

This block decides, for every load, store or instruction fetch a processor issues, whether the access may proceed. It holds a bank of protection entries; each has an 8-bit configuration byte and an address word. The configuration byte carries read, write and execute permissions, a lock flag and a 2-bit region mode. The region mode selects one of three shapes. A top-of-range region is bounded below by the previous entry's address. A naturally aligned four-byte region covers exactly one word. A naturally aligned power-of-two region is described by a trailing-ones pattern in the address word.

Each access presents its byte address, its byte length, its kind (load, store or fetch) and the current privilege level. Every entry is matched in parallel, and the lowest-numbered eligible entry that matches alone decides the outcome. Lock selects the privilege an entry applies to: locked entries govern machine mode, and unlocked entries govern supervisor and user mode. A denied access reports the access-fault code for its kind. The result is registered, so it appears one cycle after the request. The entry bank is presented as flat input vectors owned by the surrounding control-register logic.

Top module: `pmpc_checker`

## Requirements
- R1: The configuration byte of entry n sits at `cfg_bank[8n+7:8n]`, with bit 0 read, bit 1 write, bit 2 execute, bits 4:3 mode (00 off, 01 top-of-range, 10 four-byte, 11 power-of-two) and bit 7 lock. The address word of entry n sits at `addr_bank[n*(AW-2) +: AW-2]` and holds the byte address shifted right by 2.
- R2: A top-of-range entry n covers bytes from (address word of entry n-1) << 2 up to but not including (its own word) << 2. Entry 0 uses a lower bound of zero. The lower bound is taken from the previous word even when that entry is off.
- R3: A four-byte entry covers the four bytes starting at (its word) << 2.
- R4: A power-of-two entry covers every byte address that agrees with (its word) << 2 outside the mask ((word XOR (word+1)) << 2) OR 3.
- R5: An entry matches only when both the first byte and the last byte (address + length - 1, with length 0 treated as 1) lie inside its region. An entry in off mode never matches.
- R6: When several eligible entries match, the lowest-numbered one alone decides the permissions.
- R7: Privilege 2'b11 is machine, 2'b01 supervisor and 2'b00 user; any other value counts as non-machine. Machine accesses consider only locked entries, and other accesses consider only unlocked entries.
- R8: Access kind 2'b00 (load) needs read, 2'b01 (store) needs write, and 2'b10 or 2'b11 (fetch) needs execute on the deciding entry.
- R9: With no eligible match, a machine access is allowed. A non-machine access is then allowed only if every entry is off.
- R10: A denied access reports `rsp_fault` 5 for a load, 7 for a store and 1 for a fetch. An allowed access reports 0.
- R11: The result for a request sampled with `req_valid` high appears on the next cycle together with `rsp_valid` high. `rsp_valid` is `req_valid` delayed by one cycle. While `req_valid` is low, `rsp_allow` and `rsp_fault` hold their values.
- R12: While reset is asserted, `rsp_valid`, `rsp_allow` and `rsp_fault` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | AW | Byte address of the access |
| req_len | input | LEN_W | Access length in bytes |
| req_kind | input | 2 | 00 load, 01 store, 10/11 fetch |
| req_priv | input | 2 | 11 machine, 01 supervisor, 00 user |
| cfg_bank | input | 8*N_ENTRIES | Configuration bytes, entry n at bits 8n+7:8n |
| addr_bank | input | N_ENTRIES*(AW-2) | Address words, byte address >> 2 |
| rsp_valid | output | 1 | Result present |
| rsp_allow | output | 1 | Access permitted |
| rsp_fault | output | 4 | Access-fault code when denied, else 0 |

## Verification
Accesses are aimed just inside, astride and just outside each region shape. Comparing a word that ends one byte short of a top-of-range bound with one that crosses it separates start-only matching from full containment. Overlapping entries with opposite permissions are tried in both numbering orders, which shows that the lowest index decides rather than the most permissive or the most specific entry. The same addresses are issued at machine, supervisor, user and the reserved privilege code against locked and unlocked entries, and with every entry off. This separates the lock-based privilege filter and the no-match default from permission evaluation.

// File: rtl/pmpc_pkg.sv
package pmpc_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_TOR   = 2'd1,
        MODE_NA4   = 2'd2,
        MODE_NAPOT = 2'd3
    } region_mode_e;

    localparam logic [1:0] KIND_LOAD    = 2'd0;
    localparam logic [1:0] KIND_STORE   = 2'd1;
    localparam logic [1:0] PRIV_MACHINE = 2'b11;

    localparam logic [3:0] FAULT_NONE  = 4'd0;
    localparam logic [3:0] FAULT_FETCH = 4'd1;
    localparam logic [3:0] FAULT_LOAD  = 4'd5;
    localparam logic [3:0] FAULT_STORE = 4'd7;

    // Configuration byte: lock in bit 7, mode in bits 4:3, X/W/R in bits 2:0 (R1)
    typedef struct packed {
        logic         lock;
        logic [1:0]   spare;
        region_mode_e mode;
        logic         x;
        logic         w;
        logic         r;
    } entry_cfg_t;

    typedef struct packed {
        logic       valid;
        logic       allow;
        logic [3:0] fault;
    } rsp_state_t;

    function automatic logic [3:0] fault_for(input logic [1:0] kind);
        case (kind)
            KIND_LOAD:  return FAULT_LOAD;
            KIND_STORE: return FAULT_STORE;
            default:    return FAULT_FETCH;
        endcase
    endfunction

    function automatic logic perm_for(input entry_cfg_t c, input logic [1:0] kind);
        case (kind)
            KIND_LOAD:  return c.r;
            KIND_STORE: return c.w;
            default:    return c.x;
        endcase
    endfunction

endpackage

// File: rtl/pmpc_region_match.sv
module pmpc_region_match
    import pmpc_pkg::*;
#(
    parameter int AW   = 32,
    parameter int PA_W = AW - 2
) (
    input  region_mode_e    mode,
    input  logic [PA_W-1:0] cur_word,
    input  logic [PA_W-1:0] prev_word,
    input  logic [AW-1:0]   first_byte,
    input  logic [AW-1:0]   last_byte,
    output logic            hit
);

    logic [AW-1:0]   cur_base;
    logic [AW-1:0]   prev_base;
    logic [PA_W-1:0] cur_inc;
    logic [AW-1:0]   napot_mask;
    logic            tor_hit;
    logic            na4_hit;
    logic            napot_hit;

    assign cur_base   = {cur_word, 2'b00};
    assign prev_base  = {prev_word, 2'b00};
    assign cur_inc    = cur_word + 1'b1;
    assign napot_mask = {cur_word ^ cur_inc, 2'b11};

    always_comb begin
        tor_hit   = (first_byte >= prev_base) && (last_byte < cur_base);
        na4_hit   = (first_byte[AW-1:2] == cur_word) && (last_byte[AW-1:2] == cur_word);
        napot_hit = (((first_byte ^ cur_base) & ~napot_mask) == '0)
                 && (((last_byte  ^ cur_base) & ~napot_mask) == '0);
        case (mode)
            MODE_TOR:   hit = tor_hit;
            MODE_NA4:   hit = na4_hit;
            MODE_NAPOT: hit = napot_hit;
            default:    hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/pmpc_priority.sv
module pmpc_priority #(
    parameter int N_ENTRIES = 8,
    parameter int IDX_W     = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
    input  logic [N_ENTRIES-1:0] eligible,
    output logic                 found,
    output logic [IDX_W-1:0]     sel_idx
);

    always_comb begin
        found   = 1'b0;
        sel_idx = '0;
        for (int i = N_ENTRIES - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                found   = 1'b1;
                sel_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/pmpc_checker.sv
module pmpc_checker
    import pmpc_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int AW        = 32,
    parameter int LEN_W     = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      req_valid,
    input  logic [AW-1:0]             req_addr,
    input  logic [LEN_W-1:0]          req_len,
    input  logic [1:0]                req_kind,
    input  logic [1:0]                req_priv,
    input  logic [8*N_ENTRIES-1:0]    cfg_bank,
    input  logic [N_ENTRIES*(AW-2)-1:0] addr_bank,
    output logic                      rsp_valid,
    output logic                      rsp_allow,
    output logic [3:0]                rsp_fault
);

    localparam int PA_W  = AW - 2;
    localparam int IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

    entry_cfg_t           cfg_e  [N_ENTRIES];
    logic [PA_W-1:0]      word_e [N_ENTRIES];
    logic [N_ENTRIES-1:0] hit;
    logic [N_ENTRIES-1:0] active;
    logic [N_ENTRIES-1:0] eligible;
    logic                 is_machine;
    logic [LEN_W-1:0]     len_m1;
    logic [AW-1:0]        last_byte;
    logic                 found;
    logic [IDX_W-1:0]     sel_idx;
    logic                 grant;
    rsp_state_t           st_d;
    rsp_state_t           st_q;

    assign is_machine = (req_priv == PRIV_MACHINE);
    assign len_m1     = (req_len == '0) ? '0 : req_len - 1'b1;
    assign last_byte  = req_addr + AW'(len_m1);

    for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
        logic [PA_W-1:0] prev_word;

        assign cfg_e[g]  = entry_cfg_t'(cfg_bank[8*g +: 8]);
        assign word_e[g] = addr_bank[PA_W*g +: PA_W];

        if (g == 0) begin : g_first
            assign prev_word = '0;
        end else begin : g_rest
            assign prev_word = addr_bank[PA_W*(g-1) +: PA_W];
        end

        pmpc_region_match #(
            .AW   (AW),
            .PA_W (PA_W)
        ) u_match (
            .mode       (cfg_e[g].mode),
            .cur_word   (word_e[g]),
            .prev_word  (prev_word),
            .first_byte (req_addr),
            .last_byte  (last_byte),
            .hit        (hit[g])
        );

        assign active[g]   = (cfg_e[g].mode != MODE_OFF);
        assign eligible[g] = hit[g] && (cfg_e[g].lock == is_machine);
    end

    pmpc_priority #(
        .N_ENTRIES (N_ENTRIES),
        .IDX_W     (IDX_W)
    ) u_prio (
        .eligible (eligible),
        .found    (found),
        .sel_idx  (sel_idx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = req_valid;
        grant      = 1'b0;
        if (found) begin
            grant = perm_for(cfg_e[sel_idx], req_kind);
        end else begin
            grant = is_machine || (active == '0);
        end
        if (req_valid) begin
            st_d.allow = grant;
            st_d.fault = grant ? FAULT_NONE : fault_for(req_kind);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.valid;
    assign rsp_allow = st_q.allow;
    assign rsp_fault = st_q.fault;

endmodule

// File: rtl/pmpc_checker_sva.sv
module pmpc_checker_sva
    import pmpc_pkg::*;
#(
    parameter int N_ENTRIES = 8,
    parameter int AW        = 32,
    parameter int LEN_W     = 4
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        req_valid,
    input logic [AW-1:0]               req_addr,
    input logic [LEN_W-1:0]            req_len,
    input logic [1:0]                  req_kind,
    input logic [1:0]                  req_priv,
    input logic [8*N_ENTRIES-1:0]      cfg_bank,
    input logic [N_ENTRIES*(AW-2)-1:0] addr_bank,
    input logic                        rsp_valid,
    input logic                        rsp_allow,
    input logic [3:0]                  rsp_fault
);

    logic locked_any;
    logic all_off;

    always_comb begin
        locked_any = 1'b0;
        all_off    = 1'b1;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (cfg_bank[8*i+3 +: 2] != 2'b00) begin
                all_off = 1'b0;
                if (cfg_bank[8*i+7]) locked_any = 1'b1;
            end
        end
    end

    AST_VALID_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (rsp_valid == $past(req_valid)));                        // R11
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> ($stable(rsp_allow) && $stable(rsp_fault)));       // R11
    AST_ALLOW_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_allow) |-> (rsp_fault == FAULT_NONE));          // R10
    AST_FAULT_BY_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> (rsp_allow || (rsp_fault == fault_for($past(req_kind))))); // R10
    AST_MACHINE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_priv == PRIV_MACHINE) && !locked_any) |=> rsp_allow); // R9
    AST_UNPROTECTED_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && all_off) |=> rsp_allow);                            // R9

endmodule

bind pmpc_checker pmpc_checker_sva #(
    .N_ENTRIES (N_ENTRIES),
    .AW        (AW),
    .LEN_W     (LEN_W)
) u_sva (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_len   (req_len),
    .req_kind  (req_kind),
    .req_priv  (req_priv),
    .cfg_bank  (cfg_bank),
    .addr_bank (addr_bank),
    .rsp_valid (rsp_valid),
    .rsp_allow (rsp_allow),
    .rsp_fault (rsp_fault)
);

// File: tb/pmpc_checker_test.sv
`timescale 1ns/1ps
module pmpc_checker_test;

    localparam int N  = 8;
    localparam int AW = 32;
    localparam int PW = AW - 2;

    localparam logic [1:0] LD = 2'd0, ST = 2'd1, FE = 2'd2;
    localparam logic [1:0] PU = 2'b00, PS = 2'b01, PM = 2'b11;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic [AW-1:0]     req_addr = '0;
    logic [3:0]        req_len = 4'd4;
    logic [1:0]        req_kind = '0;
    logic [1:0]        req_priv = '0;
    logic [8*N-1:0]    cfg_bank = '0;
    logic [N*PW-1:0]   addr_bank = '0;
    logic              rsp_valid;
    logic              rsp_allow;
    logic [3:0]        rsp_fault;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    pmpc_checker #(.N_ENTRIES(N), .AW(AW), .LEN_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_len(req_len), .req_kind(req_kind), .req_priv(req_priv),
        .cfg_bank(cfg_bank), .addr_bank(addr_bank),
        .rsp_valid(rsp_valid), .rsp_allow(rsp_allow), .rsp_fault(rsp_fault)
    );

    function automatic logic [3:0] exp_code(input logic [1:0] k);
        return (k == LD) ? 4'd5 : (k == ST) ? 4'd7 : 4'd1;
    endfunction

    task automatic clear_all();
        cfg_bank  = '0;
        addr_bank = '0;
    endtask

    task automatic set_entry(input int idx, input logic [7:0] c, input logic [PW-1:0] w);
        cfg_bank[8*idx +: 8]   = c;
        addr_bank[PW*idx +: PW] = w;
    endtask

    task automatic access(input string tag, input logic [AW-1:0] a, input logic [3:0] len,
                          input logic [1:0] kind, input logic [1:0] priv, input logic exp_allow);
        logic [3:0] ef;
        ef        = exp_allow ? 4'd0 : exp_code(kind);
        req_addr  = a;
        req_len   = len;
        req_kind  = kind;
        req_priv  = priv;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        n_tests++;
        if (rsp_valid !== 1'b1 || rsp_allow !== exp_allow || rsp_fault !== ef) begin
            n_fail++;
            $display("FAIL %s addr=%h: valid/allow/fault act=%b/%b/%0d exp=1/%b/%0d",
                     tag, a, rsp_valid, rsp_allow, rsp_fault, exp_allow, ef);
        end
    endtask

    task automatic t_reset();
        n_tests++;
        if (rsp_valid !== 1'b0 || rsp_allow !== 1'b0 || rsp_fault !== 4'd0) begin
            n_fail++;
            $display("FAIL R12 reset act=%b/%b/%0d exp=0/0/0", rsp_valid, rsp_allow, rsp_fault);
        end
    endtask

    task automatic t_unprotected();
        clear_all();
        access("R9 all off user store", 32'h1234, 4'd2, ST, PU, 1'b1);
        access("R9 all off machine fetch", 32'h1234, 4'd4, FE, PM, 1'b1);
    endtask

    task automatic t_tor();
        clear_all();
        set_entry(0, 8'h09, 30'h400);
        set_entry(1, 8'h0B, 30'h800);
        access("R2 tor entry0 load", 32'h0800, 4'd4, LD, PU, 1'b1);
        access("R8 tor entry0 store no W", 32'h0800, 4'd4, ST, PU, 1'b0);
        access("R2 tor entry1 store", 32'h1800, 4'd8, ST, PS, 1'b1);
        access("R8 tor fetch no X", 32'h1800, 4'd4, FE, PS, 1'b0);
        access("R9 user no match", 32'h2000, 4'd4, LD, PU, 1'b0);
        access("R5 tor last byte at bound-1", 32'h0FFC, 4'd4, LD, PU, 1'b1);
        access("R5 tor straddle", 32'h0FFE, 4'd4, LD, PU, 1'b0);
        access("R7 machine ignores unlocked", 32'h0800, 4'd4, ST, PM, 1'b1);
        access("R9 machine no match", 32'h2000, 4'd4, LD, PM, 1'b1);
    endtask

    task automatic t_na4();
        clear_all();
        set_entry(2, 8'h14, 30'hC00);
        access("R3 na4 fetch", 32'h3000, 4'd4, FE, PU, 1'b1);
        access("R8 na4 kind 11 is fetch", 32'h3000, 4'd4, 2'b11, PU, 1'b1);
        access("R8 na4 load no R", 32'h3000, 4'd4, LD, PU, 1'b0);
        access("R3 na4 next word", 32'h3004, 4'd4, FE, PU, 1'b0);
        access("R5 na4 overhang", 32'h3002, 4'd4, FE, PU, 1'b0);
    endtask

    task automatic t_napot();
        clear_all();
        set_entry(3, 8'h1D, 30'h101F);
        access("R4 napot top dword", 32'h40F8, 4'd8, LD, PU, 1'b1);
        access("R5 napot overhang", 32'h40FC, 4'd8, LD, PU, 1'b0);
        access("R8 napot store no W", 32'h4010, 4'd4, ST, PU, 1'b0);
        access("R4 napot base fetch", 32'h4000, 4'd4, FE, PU, 1'b1);
        access("R4 napot below", 32'h3FFC, 4'd4, LD, PU, 1'b0);
    endtask

    task automatic t_priority();
        clear_all();
        set_entry(1, 8'h11, 30'h1400);
        set_entry(4, 8'h1F, 30'h15FF);
        access("R6 low entry read-only wins", 32'h5000, 4'd4, ST, PU, 1'b0);
        access("R6 only high entry", 32'h5004, 4'd4, ST, PU, 1'b1);
        clear_all();
        set_entry(1, 8'h1F, 30'h15FF);
        set_entry(4, 8'h11, 30'h1400);
        access("R6 low entry RWX wins", 32'h5000, 4'd4, ST, PU, 1'b1);
    endtask

    task automatic t_lock();
        clear_all();
        set_entry(0, 8'h91, 30'h1800);
        access("R7 machine locked store", 32'h6000, 4'd4, ST, PM, 1'b0);
        access("R7 machine locked load", 32'h6000, 4'd4, LD, PM, 1'b1);
        access("R7 user skips locked", 32'h6000, 4'd4, LD, PU, 1'b0);
        access("R7 reserved priv non-machine", 32'h6000, 4'd4, LD, 2'b10, 1'b0);
        access("R9 machine outside locked", 32'h7000, 4'd4, LD, PM, 1'b1);
    endtask

    task automatic t_off_bound();
        clear_all();
        set_entry(0, 8'h07, 30'h400);
        set_entry(1, 8'h0B, 30'h800);
        access("R5 off entry never matches", 32'h0800, 4'd4, LD, PU, 1'b0);
        access("R2 tor bound from off entry", 32'h1000, 4'd4, LD, PU, 1'b1);
        access("R2 below bound from off entry", 32'h0FFC, 4'd4, LD, PU, 1'b0);
        access("R1 entry byte position", 32'h1000, 4'd0, ST, PS, 1'b1);
    endtask

    task automatic t_idle_hold();
        clear_all();
        set_entry(0, 8'h09, 30'h400);
        access("R11 deny before idle", 32'h0100, 4'd4, ST, PU, 1'b0);
        req_addr = 32'h0100;
        req_kind = LD;
        req_priv = PM;
        @(negedge clk);
        n_tests++;
        if (rsp_valid !== 1'b0 || rsp_allow !== 1'b0 || rsp_fault !== 4'd7) begin
            n_fail++;
            $display("FAIL R11 idle hold act=%b/%b/%0d exp=0/0/7", rsp_valid, rsp_allow, rsp_fault);
        end
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_unprotected();
        t_tor();
        t_na4();
        t_napot();
        t_priority();
        t_lock();
        t_off_bound();
        t_idle_hold();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule